// File: doc/BRIEF.md
# Single-Port Register Writeback Arbiter

This block sits between three execution units and a register file that accepts only one write per cycle. The three units are a single-cycle ALU, a memory unit and a two-cycle non-pipelined multiplier. Each unit finishes at its own latency, so results can collide at the write port. Every unit offers a finished result with a valid flag, a destination register index, the data and an age tag. The age tag is a small issue-order counter that wraps around. Each cycle the arbiter picks one result, and that result is written in the following cycle.

A result that loses the arbitration is parked in a one-entry hold buffer that belongs to its unit. The arbiter raises a stall toward that unit until the parked result has been written. The arbiter also keeps a busy flag for the multiplier. The flag rises when a multiply is issued and stays up until that multiply's result retires. The issue stage uses it to hold back a second multiply.

Top module: `wb_arbiter`

## Requirements
- R1: In the cycle after reset is released, the write enable, all three stall outputs and the multiplier busy flag are low.
- R2: A lone valid result with a nonzero destination, presented in cycle n, appears on the write port in cycle n+1 as exactly one write-enable pulse, with its register index and data.
- R3: When several results compete, the oldest one wins. Tag a is older than tag b when the 4-bit difference (a-b) modulo 16 has its top bit set. For example, 15 is older than 0.
- R4: When competing results carry equal tags, the memory unit wins over the ALU, and the ALU wins over the multiplier.
- R5: A losing result is kept. Its unit's stall output goes high in the cycle after the conflict and stays high until the cycle in which that result is written, when the stall drops.
- R6: While a unit's stall output is high, a new result presented by that unit is ignored: it is never written and it does not replace the held result.
- R7: A result whose destination is register 0 produces no write pulse, never stalls its unit and never blocks another unit.
- R8: mul_busy rises in the cycle after mul_issue and falls in the cycle in which the multiply result is written, or in the cycle after the result is dropped for targeting register 0. A mul_issue while busy is ignored.
- R9: A held result keeps its original tag and competes with it. An older new result from another unit still beats it, and a younger one loses to it.
- R10: At most one register write occurs per cycle, and every write targets a nonzero register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_vld | input | 1 | ALU result valid |
| alu_rd | input | 5 | ALU destination register |
| alu_data | input | 32 | ALU result data |
| alu_tag | input | 4 | ALU result age tag |
| mem_vld | input | 1 | Memory unit result valid |
| mem_rd | input | 5 | Memory unit destination register |
| mem_data | input | 32 | Memory unit result data |
| mem_tag | input | 4 | Memory unit age tag |
| mul_vld | input | 1 | Multiplier result valid |
| mul_rd | input | 5 | Multiplier destination register |
| mul_data | input | 32 | Multiplier result data |
| mul_tag | input | 4 | Multiplier age tag |
| mul_issue | input | 1 | A multiply enters the multiplier |
| alu_stall | output | 1 | ALU result is held, ALU must not offer a new one |
| mem_stall | output | 1 | Memory result is held |
| mul_stall | output | 1 | Multiplier result is held |
| mul_busy | output | 1 | Multiplier occupied |
| wr_en | output | 1 | Register file write enable |
| wr_addr | output | 5 | Register file write index |
| wr_data | output | 32 | Register file write data |

## Verification
A hold buffer stuck full shows up in the next cycle as a stall that never clears and as a repeated or missing write. A buffer that drops its content shows up as a stall that falls without the matching write pulse in the same cycle. A wrong age comparison or tie order puts the wrong register index on the write port one cycle after the collision. A stale busy flag is visible in the cycle after the multiply result should have retired. The reference model compares every output on every clock, so each of these faults is reported within one or two cycles of the stimulus that exposes it.

// File: rtl/wb_pkg.sv
package wb_pkg;
    localparam int XLEN      = 32;
    localparam int RA_W      = 5;
    localparam int TAG_W     = 4;
    localparam int NUM_UNITS = 3;
    localparam int UIDX_W    = $clog2(NUM_UNITS);

    localparam int U_ALU = 0;
    localparam int U_MEM = 1;
    localparam int U_MUL = 2;

    typedef struct packed {
        logic [RA_W-1:0]  rd;
        logic [XLEN-1:0]  data;
        logic [TAG_W-1:0] tag;
    } wb_res_t;

    // a issued before b under wrap-around of the tag counter
    function automatic logic is_older(logic [TAG_W-1:0] a, logic [TAG_W-1:0] b);
        logic [TAG_W-1:0] d;
        d = a - b;
        return d[TAG_W-1];
    endfunction

    // fixed tie order: memory, then ALU, then multiplier
    function automatic logic [UIDX_W-1:0] prio_unit(int k);
        case (k)
            0:       return UIDX_W'(U_MEM);
            1:       return UIDX_W'(U_ALU);
            default: return UIDX_W'(U_MUL);
        endcase
    endfunction
endpackage

// File: rtl/wb_slot.sv
module wb_slot
    import wb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_vld,
    input  wb_res_t in_res,
    input  logic    win,
    output logic    cand_vld,
    output wb_res_t cand_res,
    output logic    full
);
    logic    full_q;
    wb_res_t hold_q;

    assign full     = full_q;
    assign cand_vld = full_q | in_vld;
    assign cand_res = full_q ? hold_q : in_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            hold_q <= '0;
        end else if (full_q) begin
            if (win) full_q <= 1'b0;
        end else if (in_vld && !win) begin
            full_q <= 1'b1;
            hold_q <= in_res;
        end
    end
endmodule

// File: rtl/wb_pick.sv
module wb_pick
    import wb_pkg::*;
(
    input  logic [NUM_UNITS-1:0] cand_vld,
    input  wb_res_t              cand_res [NUM_UNITS],
    output logic [NUM_UNITS-1:0] grant,
    output logic                 win_vld,
    output wb_res_t              win_res
);
    logic [UIDX_W-1:0] best;

    always_comb begin
        win_vld = 1'b0;
        best    = '0;
        for (int k = 0; k < NUM_UNITS; k++) begin : scan
            logic [UIDX_W-1:0] u;
            u = prio_unit(k);
            if (cand_vld[u] && (!win_vld || is_older(cand_res[u].tag, cand_res[best].tag))) begin
                win_vld = 1'b1;
                best    = u;
            end
        end
        grant = '0;
        if (win_vld) grant[best] = 1'b1;
        win_res = cand_res[best];
    end
endmodule

// File: rtl/wb_busy.sv
module wb_busy (
    input  logic clk,
    input  logic rst,
    input  logic issue,
    input  logic retire,
    output logic busy
);
    logic busy_q;
    assign busy = busy_q;

    always_ff @(posedge clk) begin
        if (rst)         busy_q <= 1'b0;
        else if (busy_q) busy_q <= !retire;
        else             busy_q <= issue;
    end
endmodule

// File: rtl/wb_arbiter.sv
module wb_arbiter
    import wb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             alu_vld,
    input  logic [RA_W-1:0]  alu_rd,
    input  logic [XLEN-1:0]  alu_data,
    input  logic [TAG_W-1:0] alu_tag,
    input  logic             mem_vld,
    input  logic [RA_W-1:0]  mem_rd,
    input  logic [XLEN-1:0]  mem_data,
    input  logic [TAG_W-1:0] mem_tag,
    input  logic             mul_vld,
    input  logic [RA_W-1:0]  mul_rd,
    input  logic [XLEN-1:0]  mul_data,
    input  logic [TAG_W-1:0] mul_tag,
    input  logic             mul_issue,
    output logic             alu_stall,
    output logic             mem_stall,
    output logic             mul_stall,
    output logic             mul_busy,
    output logic             wr_en,
    output logic [RA_W-1:0]  wr_addr,
    output logic [XLEN-1:0]  wr_data
);
    logic [NUM_UNITS-1:0] raw_vld;
    logic [NUM_UNITS-1:0] in_vld;
    wb_res_t              in_res   [NUM_UNITS];
    logic [NUM_UNITS-1:0] cand_vld;
    wb_res_t              cand_res [NUM_UNITS];
    logic [NUM_UNITS-1:0] full;
    logic [NUM_UNITS-1:0] grant;
    logic                 win_vld;
    wb_res_t              win_res;
    logic                 mul_retire;

    assign raw_vld[U_ALU] = alu_vld;
    assign raw_vld[U_MEM] = mem_vld;
    assign raw_vld[U_MUL] = mul_vld;
    assign in_res[U_ALU]  = '{rd: alu_rd, data: alu_data, tag: alu_tag};
    assign in_res[U_MEM]  = '{rd: mem_rd, data: mem_data, tag: mem_tag};
    assign in_res[U_MUL]  = '{rd: mul_rd, data: mul_data, tag: mul_tag};

    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_slot
        // writes to register zero never compete
        assign in_vld[i] = raw_vld[i] && (in_res[i].rd != '0);

        wb_slot i_slot (
            .clk      (clk),
            .rst      (rst),
            .in_vld   (in_vld[i]),
            .in_res   (in_res[i]),
            .win      (grant[i]),
            .cand_vld (cand_vld[i]),
            .cand_res (cand_res[i]),
            .full     (full[i])
        );
    end

    wb_pick i_pick (
        .cand_vld (cand_vld),
        .cand_res (cand_res),
        .grant    (grant),
        .win_vld  (win_vld),
        .win_res  (win_res)
    );

    assign mul_retire = grant[U_MUL] ||
                        (mul_vld && (mul_rd == '0) && !full[U_MUL]);

    wb_busy i_busy (
        .clk    (clk),
        .rst    (rst),
        .issue  (mul_issue),
        .retire (mul_retire),
        .busy   (mul_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= win_vld;
            wr_addr <= win_res.rd;
            wr_data <= win_res.data;
        end
    end

    assign alu_stall = full[U_ALU];
    assign mem_stall = full[U_MEM];
    assign mul_stall = full[U_MUL];
endmodule

// File: rtl/wb_arbiter_chk.sv
module wb_arbiter_chk
    import wb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             alu_vld,
    input logic             mem_vld,
    input logic             mul_vld,
    input logic             mul_issue,
    input logic             alu_stall,
    input logic             mem_stall,
    input logic             mul_stall,
    input logic             mul_busy,
    input logic             wr_en,
    input logic [RA_W-1:0]  wr_addr
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!wr_en && !alu_stall && !mem_stall && !mul_stall && !mul_busy));

    p_no_zero_write_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr != '0));

    p_write_has_source_r2: assert property (@(posedge clk) disable iff (rst)
        (!alu_vld && !mem_vld && !mul_vld && !alu_stall && !mem_stall && !mul_stall)
        |=> !wr_en);

    p_stall_from_valid_r5: assert property (@(posedge clk) disable iff (rst)
        (!alu_stall && !alu_vld) |=> !alu_stall);

    p_release_writes_r5: assert property (@(posedge clk) disable iff (rst)
        (alu_stall || mem_stall || mul_stall) |=> wr_en);

    p_busy_from_issue_r8: assert property (@(posedge clk) disable iff (rst)
        (!mul_busy && !mul_issue) |=> !mul_busy);

    p_one_release_r10: assert property (@(posedge clk) disable iff (rst)
        $countones({$fell(alu_stall), $fell(mem_stall), $fell(mul_stall)}) <= 1);
endmodule

bind wb_arbiter wb_arbiter_chk i_chk (.*);

// File: tb/test_wb_arbiter.sv
module test_wb_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alu_vld = 0, mem_vld = 0, mul_vld = 0, mul_issue = 0;
    logic [4:0]  alu_rd = 0, mem_rd = 0, mul_rd = 0;
    logic [31:0] alu_data = 0, mem_data = 0, mul_data = 0;
    logic [3:0]  alu_tag = 0, mem_tag = 0, mul_tag = 0;
    logic        alu_stall, mem_stall, mul_stall, mul_busy, wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;

    wb_arbiter i_wb_arbiter (.*);

    always #5 clk = ~clk;

    int checks = 0, failures = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference state, unit index 0=ALU 1=MEM 2=MUL
    int hf [3], hrd [3], htag [3];
    int unsigned hdat [3];
    int m_busy = 0, e_wen = 0, e_addr = 0;
    int unsigned e_data = 0;

    function automatic bit older(int a, int b);
        return (((a - b) & 15) >= 8);
    endfunction

    task automatic model_step();
        int v [3], rd [3], tg [3], cv [3], crd [3], ctg [3];
        int unsigned dt [3], cdt [3];
        int order [3] = '{1, 0, 2};
        int best = -1;
        int hf_old2 = hf[2];
        v  = '{int'(alu_vld), int'(mem_vld), int'(mul_vld)};
        rd = '{int'(alu_rd), int'(mem_rd), int'(mul_rd)};
        tg = '{int'(alu_tag), int'(mem_tag), int'(mul_tag)};
        dt = '{alu_data, mem_data, mul_data};
        for (int i = 0; i < 3; i++) begin
            if (hf[i] != 0) begin
                cv[i] = 1; crd[i] = hrd[i]; ctg[i] = htag[i]; cdt[i] = hdat[i];
            end else begin
                cv[i] = (v[i] != 0 && rd[i] != 0) ? 1 : 0;
                crd[i] = rd[i]; ctg[i] = tg[i]; cdt[i] = dt[i];
            end
        end
        for (int k = 0; k < 3; k++) begin
            int u = order[k];
            if (cv[u] != 0 && (best < 0 || older(ctg[u], ctg[best]))) best = u;
        end
        e_wen = (best >= 0) ? 1 : 0;
        if (best >= 0) begin
            e_addr = crd[best]; e_data = cdt[best];
        end
        for (int i = 0; i < 3; i++) begin
            if (hf[i] != 0) begin
                if (best == i) hf[i] = 0;
            end else if (cv[i] != 0 && best != i) begin
                hf[i] = 1; hrd[i] = crd[i]; htag[i] = ctg[i]; hdat[i] = cdt[i];
            end
        end
        if (m_busy != 0)
            m_busy = (best == 2 || (hf_old2 == 0 && v[2] != 0 && rd[2] == 0)) ? 0 : 1;
        else
            m_busy = mul_issue ? 1 : 0;
    endtask

    task automatic compare();
        checks++;
        if (wr_en !== e_wen[0] || (e_wen != 0 && (wr_addr !== e_addr[4:0] || wr_data !== e_data))) begin
            failures++;
            $display("FAIL %s write port: got en=%0b addr=%0d data=%h exp en=%0d addr=%0d data=%h",
                     cur_req, wr_en, wr_addr, wr_data, e_wen, e_addr, e_data);
        end
        checks++;
        if ({alu_stall, mem_stall, mul_stall} !== {hf[0][0], hf[1][0], hf[2][0]}) begin
            failures++;
            $display("FAIL %s stalls alu/mem/mul: got %b%b%b exp %0d%0d%0d",
                     cur_req, alu_stall, mem_stall, mul_stall, hf[0], hf[1], hf[2]);
        end
        checks++;
        if (mul_busy !== m_busy[0]) begin
            failures++;
            $display("FAIL %s mul_busy: got %b exp %0d", cur_req, mul_busy, m_busy);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #2;
        compare();
        @(negedge clk);
        alu_vld = 0; mem_vld = 0; mul_vld = 0; mul_issue = 0;
    endtask

    task automatic put_alu(int rd, int tg, int unsigned d);
        alu_vld = 1; alu_rd = 5'(rd); alu_tag = 4'(tg); alu_data = d;
    endtask
    task automatic put_mem(int rd, int tg, int unsigned d);
        mem_vld = 1; mem_rd = 5'(rd); mem_tag = 4'(tg); mem_data = d;
    endtask
    task automatic put_mul(int rd, int tg, int unsigned d);
        mul_vld = 1; mul_rd = 5'(rd); mul_tag = 4'(tg); mul_data = d;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            hf[i] = 0; hrd[i] = 0; htag[i] = 0; hdat[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        cur_req = "R1";
        tick();

        // R2: lone ALU result
        cur_req = "R2";
        put_alu(3, 0, 32'hA1A1_0003); tick();
        tick();

        // R3 and R5: older memory result beats younger ALU, ALU is held
        cur_req = "R3";
        put_mem(4, 1, 32'h0000_0404); put_alu(5, 2, 32'h0000_0505); tick();
        cur_req = "R5"; tick(); tick();

        // R3: older ALU beats younger memory
        cur_req = "R3";
        put_alu(6, 6, 32'h66); put_mem(7, 7, 32'h77); tick(); tick(); tick();

        // R3: wrap-around, 15 older than 0
        put_mem(8, 0, 32'h88); put_mul(9, 15, 32'h99); tick(); tick(); tick();

        // R4: equal tags
        cur_req = "R4";
        put_alu(10, 3, 32'h1010); put_mem(11, 3, 32'h1111); tick(); tick();
        put_alu(12, 5, 32'h1212); put_mul(13, 5, 32'h1313); tick(); tick(); tick();

        // R5: three at once
        cur_req = "R5";
        put_alu(14, 9, 32'h14); put_mem(15, 8, 32'h15); put_mul(16, 10, 32'h16);
        tick(); tick(); tick(); tick();

        // R6: new ALU result while ALU stalled is ignored
        cur_req = "R6";
        put_mem(17, 1, 32'h17); put_alu(18, 2, 32'h18); tick();
        put_alu(19, 0, 32'hDEAD_0019); put_mem(20, 3, 32'h20); tick();
        tick(); tick();

        // R7: register zero
        cur_req = "R7";
        put_alu(0, 4, 32'hFFFF); tick(); tick();
        put_alu(0, 1, 32'hEEEE); put_mem(21, 2, 32'h21); tick(); tick();

        // R9: held result keeps its tag
        cur_req = "R9";
        put_mem(22, 3, 32'h22); put_alu(23, 4, 32'h23); tick();
        put_mem(24, 2, 32'h24); tick();
        put_mem(25, 6, 32'h25); tick(); tick(); tick();

        // R8: multiplier occupancy
        cur_req = "R8";
        mul_issue = 1; tick();
        mul_issue = 1; tick();
        put_mul(26, 7, 32'h2626); tick();
        tick(); tick();
        mul_issue = 1; tick();
        tick();
        put_mul(0, 8, 32'h0); tick(); tick();
        // R8 with collision: multiply result loses, busy holds until written
        mul_issue = 1; tick(); tick();
        put_mul(27, 11, 32'h27); put_alu(28, 10, 32'h28); tick();
        tick(); tick();

        // R10: back-to-back writes, one per cycle
        cur_req = "R10";
        for (int n = 0; n < 6; n++) begin
            put_alu(1 + n, n, 32'(n * 3)); put_mem(8 + n, n, 32'(n * 5));
            tick();
            tick();
        end
        tick();

        done = 1;
        summary();
    end
endmodule